// File: doc/BRIEF.md
# Four-Channel Timer Bank

The block holds four independent 16-bit up-counters behind one 32-bit register port. Software programs each timer through four registers (count, mode, compare, hold) picked by address, and each timer drives its own interrupt line toward the system interrupt controller. A counter advances only on cycles where the shared `tick` input is high; `tick` is the output of a prescaler outside the block, so the counting rate is set there.

A timer can raise an interrupt when its count reaches the compare value, when it wraps from 0xFFFF to zero, or both. The zero-return option sends the count back to zero when an interrupt fires, which gives a periodic timer whose period is set by the compare value. Timer 0 stays armed after every firing. Timers 1 to 3 are one-shots: a firing disarms their compare interrupt. Only timers 0 and 1 have a hold register.

Each timer has a small control state machine with three states. HALT means counting was off in the previous cycle. RUN means counting was on. FIRE is entered for exactly one cycle after a tick that raised an interrupt, and it drives the interrupt output. From any state, an interrupt event goes to FIRE. Otherwise the next state is RUN if the count-up enable bit is set, and HALT if it is not.

Top module: `tmr_bank`

## Requirements
- R1: After reset every count, mode, compare and hold register reads zero and every interrupt line is low.
- R2: Timer n occupies addresses n*0x800 to n*0x800+0x7FF, with the timer index taken from `bus_addr[12:11]`. Count is at offset 0x00, mode at 0x10, compare at 0x20 and hold at 0x30. Count, compare and hold are 16 bits wide, held in `bus_wdata[15:0]` and returned in `bus_rdata[15:0]`, with bits 31:16 of a read always zero. Any other offset reads zero.
- R3: Mode bit 7 is the count-up enable. When it is set, each cycle with `tick` high adds one to the count. Without a tick, or with bit 7 clear, the count holds.
- R4: A tick that brings the count to the compare value, while mode bit 8 (compare interrupt enable) is set, is an interrupt event. It sets the compare flag, mode bit 10, and drives `irq_lines[9+n]` high for the one cycle after that tick's clock edge.
- R5: A tick at count 0xFFFF wraps the count to 0. If mode bit 9 (overflow interrupt enable) is set, this is an interrupt event that raises `irq_lines[9+n]` and, on timer 0, sets the overflow flag, mode bit 11.
- R6: With mode bit 6 (zero-return) set, the count becomes 0 on an interrupt event. With bit 6 clear, the count keeps counting past the compare value.
- R7: Timer 0 keeps its enables after an event and fires again every time its condition recurs.
- R8: On an event, timers 1, 2 and 3 clear their compare interrupt enable (bit 8) and their overflow flag (bit 11). A later compare match then raises no interrupt.
- R9: The hold register exists only on timers 0 and 1. On timers 2 and 3, hold reads zero and writes to it change no register.
- R10: Mode bits 10 and 11 clear when a 1 is written to them and are unchanged when a 0 is written. A mode write sets bits 9:6 directly from the written data.
- R11: A bus write to any register of a timer, in the same cycle as a tick, cancels that timer's tick for that cycle, so the written value is kept. Other timers still count on that tick.
- R12: Only `irq_lines[12:9]` are ever driven high; every other line stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled count pulse, one cycle per count step |
| bus_addr | input | 13 | Register address: timer index in bits 12:11, register offset in bits 10:0 |
| bus_we | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_lines | output | 16 | System interrupt lines; timer n drives line 9+n |

## Verification
A write takes effect at the rising edge where `bus_we` is high. Reads are combinational, so the bench sets the address on a falling edge and samples the data shortly after it. A tick changes the count, the flags and the one-shot disarm at the same rising edge. The interrupt line is then high from that edge until the next one, so the bench raises `tick` on one falling edge, drops it on the next falling edge, and samples `irq_lines` at that moment. One falling edge later the bench samples again to confirm the pulse lasted a single cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int MODE_LSB = 6;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_CNT,
        REG_MODE,
        REG_CMP,
        REG_HOLD
    } reg_sel_t;

    typedef struct packed {
        logic ovff;
        logic cmpf;
        logic ovfe;
        logic cmpe;
        logic cue;
        logic zret;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef enum logic [1:0] {
        T_HALT,
        T_RUN,
        T_FIRE
    } tstate_t;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int N_TMR   = 4,
    parameter int ADDR_W  = 13,
    parameter int WIN_LSB = 11,
    localparam int IDX_W  = $clog2(N_TMR)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output logic [IDX_W-1:0]  idx,
    output reg_sel_t          sel,
    output logic [N_TMR-1:0]  wr_cnt,
    output logic [N_TMR-1:0]  wr_mode,
    output logic [N_TMR-1:0]  wr_cmp,
    output logic [N_TMR-1:0]  wr_hold
);
    localparam logic [WIN_LSB-1:0] OFS_CNT  = WIN_LSB'(16'h00);
    localparam logic [WIN_LSB-1:0] OFS_MODE = WIN_LSB'(16'h10);
    localparam logic [WIN_LSB-1:0] OFS_CMP  = WIN_LSB'(16'h20);
    localparam logic [WIN_LSB-1:0] OFS_HOLD = WIN_LSB'(16'h30);

    logic [WIN_LSB-1:0] ofs;

    always_comb begin
        idx = addr[WIN_LSB +: IDX_W];
        ofs = addr[WIN_LSB-1:0];
        unique case (ofs)
            OFS_CNT:  sel = REG_CNT;
            OFS_MODE: sel = REG_MODE;
            OFS_CMP:  sel = REG_CMP;
            OFS_HOLD: sel = REG_HOLD;
            default:  sel = REG_NONE;
        endcase
    end

    always_comb begin
        for (int n = 0; n < N_TMR; n++) begin
            wr_cnt[n]  = we && (idx == IDX_W'(n)) && (sel == REG_CNT);
            wr_mode[n] = we && (idx == IDX_W'(n)) && (sel == REG_MODE);
            wr_cmp[n]  = we && (idx == IDX_W'(n)) && (sel == REG_CMP);
            wr_hold[n] = we && (idx == IDX_W'(n)) && (sel == REG_HOLD);
        end
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter bit ONE_SHOT = 1'b0,
    parameter bit HAS_HOLD = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_cnt,
    input  logic             wr_mode,
    input  logic             wr_cmp,
    input  logic             wr_hold,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_o,
    output mode_t            mode_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic [CNT_W-1:0] hold_o,
    output logic             irq_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] nxt;
    mode_t            mode_q;
    mode_t            wmode;
    tstate_t          st_q;
    tstate_t          st_d;
    logic             any_wr;
    logic             step;
    logic             cmp_hit;
    logic             ovf_hit;
    logic             fire;

    always_comb begin
        wmode   = mode_t'(wdata[MODE_LSB +: MODE_W]);
        any_wr  = wr_cnt || wr_mode || wr_cmp || wr_hold;
        step    = tick && mode_q.cue && !any_wr;
        nxt     = cnt_q + CNT_W'(1);
        cmp_hit = step && (nxt == cmp_q);
        ovf_hit = step && (cnt_q == '1);
        fire    = (cmp_hit && mode_q.cmpe) || (ovf_hit && mode_q.ovfe);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_cnt) begin
            cnt_q <= wdata;
        end else if (step) begin
            cnt_q <= (fire && mode_q.zret) ? '0 : nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_mode) begin
            mode_q.zret <= wmode.zret;
            mode_q.cue  <= wmode.cue;
            mode_q.cmpe <= wmode.cmpe;
            mode_q.ovfe <= wmode.ovfe;
            mode_q.cmpf <= mode_q.cmpf & ~wmode.cmpf;
            mode_q.ovff <= mode_q.ovff & ~wmode.ovff;
        end else begin
            if (cmp_hit && mode_q.cmpe) begin
                mode_q.cmpf <= 1'b1;
            end
            if (ovf_hit && mode_q.ovfe) begin
                mode_q.ovff <= 1'b1;
            end
            if (ONE_SHOT && fire) begin
                mode_q.cmpe <= 1'b0;
                mode_q.ovff <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (wr_cmp) begin
            cmp_q <= wdata;
        end
    end

    generate
        if (HAS_HOLD) begin : g_hold
            logic [CNT_W-1:0] hold_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hold_q <= '0;
                end else if (wr_hold) begin
                    hold_q <= wdata;
                end
            end
            assign hold_o = hold_q;
        end else begin : g_nohold
            assign hold_o = '0;
        end
    endgenerate

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= T_HALT;
        end else begin
            st_q <= st_d;
        end
    end

    // next-state logic
    always_comb begin
        unique case (st_q)
            T_HALT:  st_d = fire ? T_FIRE : (mode_q.cue ? T_RUN : T_HALT);
            T_RUN:   st_d = fire ? T_FIRE : (mode_q.cue ? T_RUN : T_HALT);
            T_FIRE:  st_d = fire ? T_FIRE : (mode_q.cue ? T_RUN : T_HALT);
            default: st_d = T_HALT;
        endcase
    end

    // outputs
    always_comb begin
        unique case (st_q)
            T_FIRE:  irq_o = 1'b1;
            default: irq_o = 1'b0;
        endcase
    end

    assign cnt_o  = cnt_q;
    assign mode_o = mode_q;
    assign cmp_o  = cmp_q;
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int N_TMR    = 4,
    parameter int N_HOLD   = 2,
    parameter int CNT_W    = 16,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 13,
    parameter int WIN_LSB  = 11,
    parameter int IRQ_BASE = 9,
    parameter int IRQ_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [IRQ_W-1:0]  irq_lines
);
    localparam int IDX_W = $clog2(N_TMR);

    logic [IDX_W-1:0]      idx;
    reg_sel_t              sel;
    logic [N_TMR-1:0]      wr_cnt;
    logic [N_TMR-1:0]      wr_mode;
    logic [N_TMR-1:0]      wr_cmp;
    logic [N_TMR-1:0]      wr_hold;
    logic [N_TMR-1:0]      irq_v;
    logic [CNT_W-1:0]      cnt_a  [N_TMR];
    logic [CNT_W-1:0]      cmp_a  [N_TMR];
    logic [CNT_W-1:0]      hold_a [N_TMR];
    mode_t                 mode_a [N_TMR];
    logic [N_TMR*CNT_W-1:0] cnt_flat;
    logic [N_TMR-1:0]      cue_v;
    logic [N_TMR-1:0]      cmpe_v;
    logic [N_TMR-1:0]      zret_v;

    tmr_decode #(
        .N_TMR  (N_TMR),
        .ADDR_W (ADDR_W),
        .WIN_LSB(WIN_LSB)
    ) u_dec (
        .addr   (bus_addr),
        .we     (bus_we),
        .idx    (idx),
        .sel    (sel),
        .wr_cnt (wr_cnt),
        .wr_mode(wr_mode),
        .wr_cmp (wr_cmp),
        .wr_hold(wr_hold)
    );

    generate
        for (genvar n = 0; n < N_TMR; n++) begin : g_tmr
            tmr_chan #(
                .CNT_W   (CNT_W),
                .ONE_SHOT(n != 0),
                .HAS_HOLD(n < N_HOLD)
            ) u_chan (
                .clk    (clk),
                .rst_n  (rst_n),
                .tick   (tick),
                .wr_cnt (wr_cnt[n]),
                .wr_mode(wr_mode[n]),
                .wr_cmp (wr_cmp[n]),
                .wr_hold(wr_hold[n]),
                .wdata  (bus_wdata[CNT_W-1:0]),
                .cnt_o  (cnt_a[n]),
                .mode_o (mode_a[n]),
                .cmp_o  (cmp_a[n]),
                .hold_o (hold_a[n]),
                .irq_o  (irq_v[n])
            );
            assign cnt_flat[n*CNT_W +: CNT_W] = cnt_a[n];
            assign cue_v[n]  = mode_a[n].cue;
            assign cmpe_v[n] = mode_a[n].cmpe;
            assign zret_v[n] = mode_a[n].zret;
        end
    endgenerate

    always_comb begin
        irq_lines = '0;
        for (int n = 0; n < N_TMR; n++) begin
            irq_lines[IRQ_BASE + n] = irq_v[n];
        end
    end

    always_comb begin
        unique case (sel)
            REG_CNT:  bus_rdata = DATA_W'(cnt_a[idx]);
            REG_MODE: bus_rdata = DATA_W'({mode_a[idx], {MODE_LSB{1'b0}}});
            REG_CMP:  bus_rdata = DATA_W'(cmp_a[idx]);
            REG_HOLD: bus_rdata = DATA_W'(hold_a[idx]);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
    parameter int N_TMR    = 4,
    parameter int CNT_W    = 16,
    parameter int ADDR_W   = 13,
    parameter int DATA_W   = 32,
    parameter int IRQ_BASE = 9,
    parameter int IRQ_W    = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   tick,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_we,
    input logic [DATA_W-1:0]      bus_rdata,
    input logic [IRQ_W-1:0]       irq_lines,
    input logic [N_TMR*CNT_W-1:0] cnt_flat,
    input logic [N_TMR-1:0]       cue_v,
    input logic [N_TMR-1:0]       cmpe_v,
    input logic [N_TMR-1:0]       zret_v
);
    AST_FROZEN_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick) && !$past(bus_we)) |-> $stable(cnt_flat)); // R3

    AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lines[IRQ_BASE +: N_TMR] != '0) |-> $past(tick)); // R4

    AST_ABSENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[12] && bus_addr[10:0] == 11'h030) |-> (bus_rdata == '0)); // R9

    generate
        for (genvar n = 0; n < N_TMR; n++) begin : g_chk
            logic [CNT_W-1:0] c;
            assign c = cnt_flat[n*CNT_W +: CNT_W];

            AST_ZRET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
                (irq_lines[IRQ_BASE + n] && zret_v[n]) |-> (c == '0)); // R6

            AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                $past(tick && !bus_we && cue_v[n] && (c == '1)) |-> (c == '0)); // R5

            if (n != 0) begin : g_one
                AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
                    irq_lines[IRQ_BASE + n] |-> !cmpe_v[n]); // R8
            end
        end
    endgenerate
endmodule

bind tmr_bank tmr_bank_chk #(
    .N_TMR   (N_TMR),
    .CNT_W   (CNT_W),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .IRQ_BASE(IRQ_BASE),
    .IRQ_W   (IRQ_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_rdata(bus_rdata),
    .irq_lines(irq_lines),
    .cnt_flat (cnt_flat),
    .cue_v    (cue_v),
    .cmpe_v   (cmpe_v),
    .zret_v   (zret_v)
);

// File: tb/sim_tmr_bank.sv
`timescale 1ns/1ps
module sim_tmr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [12:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_lines;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tmr_bank u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_lines(irq_lines)
    );

    function automatic logic [12:0] ba(int t, int ofs);
        return 13'(t * 'h800 + ofs);
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [12:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic rdchk(string req, string what, logic [12:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, what, d, exp);
    endtask

    task automatic tk(output logic [15:0] irqs);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        irqs = irq_lines;
    endtask

    task automatic clear_all();
        for (int t = 0; t < 4; t++) begin
            wr(ba(t, 'h10), 32'h0000_0C00);
            wr(ba(t, 'h00), 32'h0);
        end
    endtask

    task automatic t_reset();
        rdchk("R1", "count0", ba(0, 'h00), 0);
        rdchk("R1", "mode2", ba(2, 'h10), 0);
        rdchk("R1", "compare3", ba(3, 'h20), 0);
        rdchk("R1", "hold1", ba(1, 'h30), 0);
        chk("R1", "irq lines", {16'h0, irq_lines}, 0);
    endtask

    task automatic t_decode();
        for (int t = 0; t < 4; t++) begin
            wr(ba(t, 'h00), 32'hABCD_0100 + t);
            wr(ba(t, 'h20), 32'h0000_0200 + t);
        end
        for (int t = 0; t < 4; t++) begin
            rdchk("R2", "count by index", ba(t, 'h00), 32'h0100 + t);
            rdchk("R2", "compare by index", ba(t, 'h20), 32'h0200 + t);
        end
        rdchk("R2", "unmapped offset", ba(1, 'h40), 0);
    endtask

    task automatic t_count();
        logic [15:0] q;
        clear_all();
        wr(ba(0, 'h00), 5);
        wr(ba(0, 'h10), 32'h80);
        for (int i = 0; i < 3; i++) tk(q);
        rdchk("R3", "count after 3 ticks", ba(0, 'h00), 8);
        repeat (4) @(negedge clk);
        rdchk("R3", "count holds without tick", ba(0, 'h00), 8);
        wr(ba(0, 'h10), 32'h0);
        tk(q);
        rdchk("R3", "count holds with enable off", ba(0, 'h00), 8);
    endtask

    task automatic t_compare();
        logic [15:0] q;
        clear_all();
        wr(ba(0, 'h20), 3);
        wr(ba(0, 'h10), 32'h180);
        tk(q); chk("R4", "no irq at count 1", {16'h0, q}, 0);
        tk(q); chk("R4", "no irq at count 2", {16'h0, q}, 0);
        tk(q); chk("R4", "irq at match", {16'h0, q}, 32'h0200);
        chk("R12", "only line 9 active", {16'h0, q & 16'hE1FF}, 0);
        @(negedge clk);
        chk("R4", "irq lasts one cycle", {16'h0, irq_lines}, 0);
        rdchk("R4", "compare flag set", ba(0, 'h10), 32'h580);
        rdchk("R6", "no zero-return keeps count", ba(0, 'h00), 3);
        tk(q);
        rdchk("R6", "count passes compare", ba(0, 'h00), 4);
        wr(ba(0, 'h10), 32'h180);
        rdchk("R10", "write 0 keeps flag", ba(0, 'h10), 32'h580);
        wr(ba(0, 'h10), 32'h580);
        rdchk("R10", "write 1 clears flag", ba(0, 'h10), 32'h180);
    endtask

    task automatic t_periodic();
        logic [15:0] q;
        clear_all();
        wr(ba(0, 'h20), 2);
        wr(ba(0, 'h10), 32'h1C0);
        for (int p = 0; p < 3; p++) begin
            tk(q); chk("R7", "no irq mid period", {16'h0, q}, 0);
            tk(q); chk("R7", "periodic irq", {16'h0, q}, 32'h0200);
            rdchk("R6", "zero-return count", ba(0, 'h00), 0);
        end
        rdchk("R7", "timer0 stays armed", ba(0, 'h10), 32'h5C0);
    endtask

    task automatic t_overflow();
        logic [15:0] q;
        clear_all();
        wr(ba(0, 'h20), 32'h1234);
        wr(ba(0, 'h00), 32'hFFFE);
        wr(ba(0, 'h10), 32'h280);
        tk(q); chk("R5", "no irq at 0xFFFF", {16'h0, q}, 0);
        tk(q); chk("R5", "irq on wrap", {16'h0, q}, 32'h0200);
        rdchk("R5", "count wrapped", ba(0, 'h00), 0);
        rdchk("R5", "overflow flag", ba(0, 'h10), 32'hA80);
    endtask

    task automatic t_oneshot();
        logic [15:0] q;
        for (int t = 1; t < 4; t++) begin
            clear_all();
            wr(ba(t, 'h20), 2);
            wr(ba(t, 'h10), 32'h1C0);
            tk(q);
            tk(q); chk("R8", "one-shot first irq", {16'h0, q}, 32'h1 << (9 + t));
            rdchk("R8", "compare enable cleared", ba(t, 'h10), 32'h4C0);
            tk(q);
            tk(q); chk("R8", "no second irq", {16'h0, q}, 0);
            rdchk("R8", "count past compare", ba(t, 'h00), 2);
        end
        clear_all();
        wr(ba(2, 'h00), 32'hFFFF);
        wr(ba(2, 'h10), 32'h280);
        tk(q); chk("R8", "timer2 wrap irq", {16'h0, q}, 32'h0800);
        rdchk("R8", "overflow flag cleared", ba(2, 'h10), 32'h280);
    endtask

    task automatic t_hold();
        wr(ba(2, 'h00), 32'h77);
        for (int t = 0; t < 4; t++) wr(ba(t, 'h30), 32'h1111 * (t + 1));
        rdchk("R9", "hold0", ba(0, 'h30), 32'h1111);
        rdchk("R9", "hold1", ba(1, 'h30), 32'h2222);
        rdchk("R9", "hold2 absent", ba(2, 'h30), 0);
        rdchk("R9", "hold3 absent", ba(3, 'h30), 0);
        rdchk("R9", "timer2 count untouched", ba(2, 'h00), 32'h77);
    endtask

    task automatic t_write_tick();
        clear_all();
        wr(ba(0, 'h00), 10);
        wr(ba(0, 'h10), 32'h80);
        wr(ba(3, 'h10), 32'h80);
        @(negedge clk);
        tick = 1'b1; bus_addr = ba(0, 'h00); bus_wdata = 32'h50; bus_we = 1'b1;
        @(negedge clk);
        tick = 1'b0; bus_we = 1'b0;
        rdchk("R11", "write wins over tick", ba(0, 'h00), 32'h50);
        rdchk("R11", "other timer counts", ba(3, 'h00), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_decode();
        t_count();
        t_compare();
        t_periodic();
        t_overflow();
        t_oneshot();
        t_hold();
        t_write_tick();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule